// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a 32-bit down-counting watchdog that sits on a simple zero-wait-state register bus. Software programs a start value, sets the run bit and must then keep returning to reload the counter. If the counter reaches zero and is allowed to step past it, the first such expiry raises an interrupt and restarts the count from the programmed value. If software still has not cleared that interrupt when the next expiry arrives, and reset escalation is enabled, the block raises a system reset request that holds until the block itself is reset.

Every register except the lock register is write-protected by a key. The block leaves reset locked. A write of the unlock key to the lock register opens the other registers, and a write of any other value closes them again. Reads are never blocked. The bus has no data stream: every access completes in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. The ready output is held high at all times.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the block is locked, the control register reads 0, the start value and the live count both read 0xFFFFFFFF, the status reads 0, and neither the interrupt nor the reset request is asserted.
- R2: The lock register is at offset 0x40. Writing 0x1ACCE551 there unlocks the block and writing any other value locks it. Reading it returns 1 when locked and 0 when unlocked.
- R3: While the block is locked, writes to the start value, control and clear registers have no effect.
- R4: The control register is at offset 0x08. Bit 0 is the run bit, which enables both counting and interrupt generation. Bit 1 enables reset escalation. Bits 31:2 read as zero whatever value is written to them.
- R5: An unlocked write to the start-value register at offset 0x00 stores the value and copies it into the counter on the same clock edge.
- R6: While the run bit is set, the counter decreases by one on every clock edge. While the run bit is clear, the counter holds its value.
- R7: If the run bit is set and the counter is at zero, the next clock edge sets the interrupt and reloads the counter from the start value.
- R8: An unlocked write to the clear register at offset 0x0C with bit 0 set clears the interrupt and reloads the counter from the start value.
- R9: An expiry that finds the interrupt already pending sets the reset request if bit 1 of the control register is set, and leaves it low otherwise. Once set, the reset request stays high until the block is reset.
- R10: The status register at offset 0x10 reads 1 while the interrupt is pending and 0 otherwise. The count register at offset 0x04 returns the live counter value, and unmapped offsets read as 0.
- R11: The ready output is always high. Read data follows the address combinationally, in the same cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase strobe; a write takes effect on the edge where psel, penable and pwrite are all high |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr |
| pready | output | 1 | Always high |
| irq | output | 1 | First-expiry interrupt, active high |
| rst_req | output | 1 | Sticky system reset request |

## Verification
A register write takes effect on the clock edge that closes the access phase. The counter has already stepped once, on the setup edge of the same write, when the run bit was set at that edge. The interrupt and the reset request change on the edge that follows the one that brought the counter to zero. A write of start value L with the run bit already set therefore gives the interrupt L+1 edges later. The bench advances time only at falling edges, and every reload expectation is counted from the commit edge of the last write. It compares read data, irq and rst_req at a fixed short delay after a falling edge, so each result is sampled half a period after the edge that produced it.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 8;

  localparam logic [OFS_W-1:0] OFS_START  = 8'h00;
  localparam logic [OFS_W-1:0] OFS_COUNT  = 8'h04;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 8'h08;
  localparam logic [OFS_W-1:0] OFS_CLEAR  = 8'h0C;
  localparam logic [OFS_W-1:0] OFS_STATUS = 8'h10;
  localparam logic [OFS_W-1:0] OFS_LOCK   = 8'h40;

  localparam logic [WORD_W-1:0] OPEN_KEY = 32'h1ACC_E551;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_ESC_BIT = 1;
  localparam int unsigned CLEAR_BIT    = 0;

  typedef struct packed {
    logic esc_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdk_regfile.sv
module wdk_regfile
  import wdk_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned AW = OFS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic          locked,
  output ctrl_t         ctrl,
  output logic [DW-1:0] start_val,
  output logic          start_wr,
  output logic          clear_wr
);
  logic wr_any, wr_open;

  assign wr_any   = psel & penable & pwrite;
  assign wr_open  = wr_any & ~locked;
  assign start_wr = wr_open & (paddr == AW'(OFS_START));
  assign clear_wr = wr_open & (paddr == AW'(OFS_CLEAR)) & pwdata[CLEAR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b1;
      ctrl      <= '0;
      start_val <= '1;
    end else begin
      if (wr_any && paddr == AW'(OFS_LOCK))
        locked <= (pwdata != DW'(OPEN_KEY));
      if (wr_open && paddr == AW'(OFS_CTRL)) begin
        ctrl.run    <= pwdata[CTRL_RUN_BIT];
        ctrl.esc_en <= pwdata[CTRL_ESC_BIT];
      end
      if (start_wr)
        start_val <= pwdata;
    end
  end
endmodule

// File: rtl/wdk_counter.sv
module wdk_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          start_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          clear_wr,
  input  logic [DW-1:0] start_val,
  output logic [DW-1:0] count,
  output logic          expire
);
  logic at_zero;

  assign at_zero = (count == '0);
  // bus writes take precedence; an expiry is only signalled when no write reloads
  assign expire  = run & at_zero & ~start_wr & ~clear_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count <= '1;
    else if (start_wr)
      count <= wr_data;
    else if (clear_wr)
      count <= start_val;
    else if (run)
      count <= at_zero ? start_val : count - 1'b1;
  end
endmodule

// File: rtl/wdk_escalate.sv
module wdk_escalate (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clear_wr,
  input  logic esc_en,
  output logic irq,
  output logic rst_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (clear_wr)
        irq <= 1'b0;
      else if (expire)
        irq <= 1'b1;
      if (expire && irq && esc_en)
        rst_req <= 1'b1;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import wdk_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned AW = OFS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          irq,
  output logic          rst_req
);
  logic          locked;
  ctrl_t         ctrl;
  logic [DW-1:0] start_val;
  logic          start_wr;
  logic          clear_wr;
  logic [DW-1:0] count;
  logic          expire;

  wdk_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .locked(locked), .ctrl(ctrl),
    .start_val(start_val), .start_wr(start_wr), .clear_wr(clear_wr)
  );

  wdk_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl.run), .start_wr(start_wr),
    .wr_data(pwdata), .clear_wr(clear_wr), .start_val(start_val),
    .count(count), .expire(expire)
  );

  wdk_escalate u_esc (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clear_wr(clear_wr),
    .esc_en(ctrl.esc_en), .irq(irq), .rst_req(rst_req)
  );

  assign pready = 1'b1;

  always_comb begin
    prdata = '0;
    if (paddr == AW'(OFS_START))       prdata = start_val;
    else if (paddr == AW'(OFS_COUNT))  prdata = count;
    else if (paddr == AW'(OFS_CTRL))   prdata = DW'(ctrl);
    else if (paddr == AW'(OFS_STATUS)) prdata = DW'(irq);
    else if (paddr == AW'(OFS_LOCK))   prdata = DW'(locked);
  end
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
  import wdk_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned AW = OFS_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] pwdata,
  input logic          pready,
  input logic          irq,
  input logic          rst_req,
  input logic          locked,
  input logic          run,
  input logic          esc_en,
  input logic [DW-1:0] start_val,
  input logic [DW-1:0] count
);
  logic wr_any, wr_open;
  assign wr_any  = psel & penable & pwrite;
  assign wr_open = wr_any & ~locked;

  always_comb a_r11_ready_high: assert (pready === 1'b1);

  a_r2_lock_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && paddr == AW'(OFS_LOCK)) |=> (locked == ($past(pwdata) != DW'(OPEN_KEY))));

  a_r3_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && locked && paddr != AW'(OFS_LOCK))
      |=> ($stable(start_val) && $stable(run) && $stable(esc_en)));

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_open) |=> $stable(count));

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && count != '0 && !wr_open) |=> (count == $past(count) - 1'b1));

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(run) && $past(count) == '0));

  a_r9_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(irq) && $past(esc_en)));

  a_r9_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
endmodule

bind keyed_wdog wdk_checker #(.DW(DW), .AW(AW)) u_wdk_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pready(pready), .irq(irq), .rst_req(rst_req),
  .locked(locked), .run(ctrl.run), .esc_en(ctrl.esc_en), .start_val(start_val),
  .count(count)
);

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_START = 8'h00, A_COUNT = 8'h04, A_CTRL = 8'h08,
                         A_CLEAR = 8'h0C, A_STAT = 8'h10, A_LOCK = 8'h40;
  localparam logic [31:0] KEY = 32'h1ACC_E551;
  localparam int K_RD = 0, K_IRQ = 1, K_RST = 2, K_RDY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, irq, rst_req;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct {
    int kind;
    logic [31:0] exp;
    string tag;
  } item_t;
  item_t sb[$];
  event smp_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdog i_keyed_wdog (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .irq(irq), .rst_req(rst_req)
  );

  // monitor: pops expected items and compares against the design
  initial begin
    forever begin
      @(smp_ev);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          K_RD:    act = prdata;
          K_IRQ:   act = {31'b0, irq};
          K_RST:   act = {31'b0, rst_req};
          default: act = {31'b0, pready};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    paddr = a; psel = 1'b1; penable = 1'b1; pwrite = 1'b0;
    #1;
    it.kind = K_RD; it.exp = e; it.tag = tag;
    sb.push_back(it);
    ->smp_ev;
    #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic expect_pin(input int k, input logic e, input string tag);
    item_t it;
    #1;
    it.kind = k; it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
    ->smp_ev;
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(A_LOCK, 32'd1, "R1 lock");
    expect_rd(A_CTRL, 32'd0, "R1 ctrl");
    expect_rd(A_START, 32'hFFFF_FFFF, "R1 start");
    expect_rd(A_COUNT, 32'hFFFF_FFFF, "R1 count");
    expect_rd(A_STAT, 32'd0, "R1 status");
    expect_pin(K_IRQ, 1'b0, "R1 irq");
    expect_pin(K_RST, 1'b0, "R1 rst_req");
    expect_pin(K_RDY, 1'b1, "R11 ready");
    expect_rd(8'h30, 32'd0, "R10 unmapped");

    // R3 writes ignored while locked
    wr(A_START, 32'd5);
    wr(A_CTRL, 32'd3);
    expect_rd(A_START, 32'hFFFF_FFFF, "R3 start locked");
    expect_rd(A_CTRL, 32'd0, "R3 ctrl locked");
    expect_rd(A_COUNT, 32'hFFFF_FFFF, "R3 count locked");

    // R2 key handling
    wr(A_LOCK, KEY);
    expect_rd(A_LOCK, 32'd0, "R2 unlock");
    wr(A_LOCK, 32'h1ACC_E550);
    expect_rd(A_LOCK, 32'd1, "R2 wrong key relocks");
    wr(A_START, 32'd7);
    expect_rd(A_START, 32'hFFFF_FFFF, "R3 after relock");
    wr(A_LOCK, KEY);

    // R4 reserved bits
    wr(A_CTRL, 32'hFFFF_FFFC);
    expect_rd(A_CTRL, 32'd0, "R4 reserved zero");

    // R5 start write copies into counter, R6 frozen
    wr(A_START, 32'd100);
    expect_rd(A_COUNT, 32'd100, "R5 count loaded");
    tick(3);
    expect_rd(A_COUNT, 32'd100, "R6 frozen when idle");

    // R6 counting
    wr(A_CTRL, 32'd1);
    expect_rd(A_CTRL, 32'd1, "R4 run bit");
    expect_rd(A_COUNT, 32'd100, "R6 no step on enable edge");
    tick(10);
    expect_rd(A_COUNT, 32'd90, "R6 step per clock");

    // R7 first expiry
    wr(A_START, 32'd20);
    expect_rd(A_COUNT, 32'd20, "R5 load while running");
    tick(20);
    expect_rd(A_COUNT, 32'd0, "R6 reaches zero");
    expect_pin(K_IRQ, 1'b0, "R7 no irq at zero");
    tick(1);
    expect_pin(K_IRQ, 1'b1, "R7 irq on expiry");
    expect_rd(A_COUNT, 32'd20, "R7 reload");
    expect_rd(A_STAT, 32'd1, "R10 status pending");

    // R8 clear
    wr(A_CLEAR, 32'd1);
    expect_pin(K_IRQ, 1'b0, "R8 irq cleared");
    expect_rd(A_STAT, 32'd0, "R10 status clear");
    expect_rd(A_COUNT, 32'd20, "R8 clear reloads");

    // R9 second expiry without escalation
    tick(21);
    expect_pin(K_IRQ, 1'b1, "R7 irq again");
    tick(21);
    expect_pin(K_RST, 1'b0, "R9 no reset when disabled");
    expect_pin(K_IRQ, 1'b1, "R9 irq held");
    expect_rd(A_COUNT, 32'd20, "R7 reload at second expiry");

    // R3 clear ignored while locked
    wr(A_LOCK, 32'd0);
    wr(A_CLEAR, 32'd1);
    expect_pin(K_IRQ, 1'b1, "R3 clear locked");
    wr(A_CTRL, 32'd0);
    expect_rd(A_CTRL, 32'd1, "R3 ctrl write locked");
    wr(A_LOCK, KEY);

    // R9 escalation
    wr(A_CTRL, 32'd3);
    wr(A_START, 32'd20);
    tick(20);
    expect_pin(K_RST, 1'b0, "R9 not yet");
    tick(1);
    expect_pin(K_RST, 1'b1, "R9 reset on second expiry");

    // R6 freeze by clearing run bit
    wr(A_CTRL, 32'd2);
    expect_rd(A_COUNT, 32'd18, "R6 stop value");
    tick(5);
    expect_rd(A_COUNT, 32'd18, "R6 frozen");
    wr(A_CLEAR, 32'd1);
    expect_pin(K_IRQ, 1'b0, "R8 clear after escalation");
    expect_pin(K_RST, 1'b1, "R9 sticky");
    expect_rd(A_COUNT, 32'd20, "R8 reload while stopped");

    // block reset releases request
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    expect_pin(K_RST, 1'b0, "R9 released by block reset");
    expect_rd(A_LOCK, 32'd1, "R1 locked again");

    // first expiry with escalation enabled only interrupts
    wr(A_LOCK, KEY);
    wr(A_CTRL, 32'd3);
    wr(A_START, 32'd5);
    tick(6);
    expect_pin(K_IRQ, 1'b1, "R7 irq short count");
    expect_pin(K_RST, 1'b0, "R9 first expiry no reset");
    tick(6);
    expect_pin(K_RST, 1'b1, "R9 escalated");

    finish_run();
  end
endmodule